// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a two-channel serial audio stream and turns it into parallel samples for a downstream audio datapath. Three inputs carry the stream: a bit clock, a word-select line that frames left and right half-frames, and a serial data line. The block is a slave only, so both clocks come from outside. It samples all three lines with its own faster system clock, finds each rising edge of the bit clock, and takes one data bit at each of those edges.

A 2-bit format input selects how each sample sits inside its half-frame. Two formats align the data to the end of the half-frame (16-bit and 18-bit). One aligns the 18-bit data to the start of the half-frame. One is the common inter-IC framing, where the data starts one bit clock after the word-select change. The number of bit clocks per half-frame may vary within the limits that each format allows. Every sample leaves the block as an 18-bit two's-complement word on its channel's data output. A one-cycle valid strobe marks it once the channel's half-frame has ended.

Top module: `aud_rx`

## Requirements
- R1: The format input selects the framing. 2'b00 is 16-bit end-aligned. 2'b01 is 18-bit end-aligned. 2'b10 is 18-bit start-aligned. 2'b11 is 18-bit inter-IC framing with a one-bit delay.
- R2: Data is taken only at rising edges of the bit clock, most significant bit first, in two's complement.
- R3: In the end-aligned formats (00, 01), the sample is made of the last 16 or 18 bits before the word-select transition. Bits that arrive earlier in the half-frame are ignored, for any half-frame length of at least the word width.
- R4: In format 00, the 16-bit sample is sign-extended to 18 bits: output bits 17 and 16 equal bit 15.
- R5: In format 10, the sample is made of the 18 bits that start at the first rising edge after the word-select transition. Later bits in the half-frame are ignored.
- R6: In format 11, the sample starts at the second rising edge after the word-select transition. Word-select low marks the left channel.
- R7: In format 11 with 16 bit clocks per half-frame, the 16 bits received fill output bits 17..2, and bits 1..0 are zero.
- R8: In formats 00, 01 and 10, word-select high marks the left channel.
- R9: Each received sample raises its channel's valid for exactly one clock cycle, with the data on the same cycle. The two valids are never high together, and every completed half-frame gives exactly one strobe.
- R10: Reset is asynchronous and active low. During reset both data outputs are zero and both valids are low. The half-frame that is in progress when data starts after reset produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Framing select (see R1) |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Word-select / channel framing |
| sdata | input | 1 | Serial data |
| left_data | output | 18 | Latest left sample |
| left_vld | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 18 | Latest right sample |
| right_vld | output | 1 | One-cycle strobe for a new right sample |

## Verification
The hardest case to reach is inter-IC framing with a 16-bit half-frame. There, the least significant bit of each channel arrives after word-select has already switched to the other channel. The strobe must therefore wait one more bit clock, and the low output bits must be zero-filled. The stimulus builds each half-frame bit by bit. In inter-IC framing it delays the whole data line by one slot against word-select, so the last bit of one channel always lands in the first slot of the next. Sweeps over half-frame lengths of 16, 17, 18, 24 and 32 move the don't-care padding before or after the data. Samples at the sign boundaries expose any slip of one bit.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_END16   = 2'b00,
    FMT_END18   = 2'b01,
    FMT_START18 = 2'b10,
    FMT_IIC     = 2'b11
  } fmt_e;

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdata,
  output logic bit_stb,
  output logic bit_val,
  output logic lr_val
);

  logic [STAGES-1:0] b_q, b_d;
  logic [STAGES-1:0] l_q, l_d;
  logic [STAGES-1:0] s_q, s_d;
  logic              b_prev_q, b_prev_d;

  always_comb begin
    b_d      = {b_q[STAGES-2:0], bclk};
    l_d      = {l_q[STAGES-2:0], lrclk};
    s_d      = {s_q[STAGES-2:0], sdata};
    b_prev_d = b_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q      <= '0;
      l_q      <= '0;
      s_q      <= '0;
      b_prev_q <= 1'b0;
    end else begin
      b_q      <= b_d;
      l_q      <= l_d;
      s_q      <= s_d;
      b_prev_q <= b_prev_d;
    end
  end

  assign bit_stb = b_q[STAGES-1] & ~b_prev_q;
  assign bit_val = s_q[STAGES-1];
  assign lr_val  = l_q[STAGES-1];

endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
  import aud_rx_pkg::*;
#(
  parameter int W  = 18,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt,
  input  logic          bit_stb,
  input  logic          bit_val,
  input  logic          lr_val,
  output logic          word_stb,
  output logic          word_left,
  output logic [W-1:0]  lsb_word,
  output logic [W-1:0]  msb_word,
  output logic [CW-1:0] msb_cnt
);

  localparam logic [CW-1:0] W_C = CW'(W);

  logic          lr1_q, lr1_d, lr2_q, lr2_d;
  logic [1:0]    hist_q, hist_d;
  logic          armed_q, armed_d;
  logic [W-1:0]  lsr_q, lsr_d, msr_q, msr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stb_d, left_d;
  logic [W-1:0]  lword_d, mword_d;
  logic [CW-1:0] mcnt_d;
  logic          iic, fr_now, fr_old, hist_ok, bound;

  always_comb begin
    iic     = (fmt == FMT_IIC);
    fr_now  = iic ? lr1_q : lr_val;
    fr_old  = iic ? lr2_q : lr1_q;
    hist_ok = (hist_q == 2'd2);
    bound   = bit_stb && hist_ok && (fr_now != fr_old);

    lr1_d   = lr1_q;
    lr2_d   = lr2_q;
    hist_d  = hist_q;
    armed_d = armed_q;
    lsr_d   = lsr_q;
    msr_d   = msr_q;
    cnt_d   = cnt_q;
    stb_d   = 1'b0;
    left_d  = word_left;
    lword_d = lsb_word;
    mword_d = msb_word;
    mcnt_d  = msb_cnt;

    if (bit_stb) begin
      lr1_d  = lr_val;
      lr2_d  = lr1_q;
      hist_d = hist_ok ? hist_q : hist_q + 2'd1;
      lsr_d  = {lsr_q[W-2:0], bit_val};
      if (bound) begin
        armed_d = 1'b1;
        stb_d   = armed_q;
        left_d  = iic ? ~fr_old : fr_old;
        lword_d = lsr_q;
        mword_d = msr_q;
        mcnt_d  = cnt_q;
        msr_d   = {{(W-1){1'b0}}, bit_val};
        cnt_d   = CW'(1);
      end else if (cnt_q < W_C) begin
        msr_d = {msr_q[W-2:0], bit_val};
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr1_q     <= 1'b0;
      lr2_q     <= 1'b0;
      hist_q    <= 2'd0;
      armed_q   <= 1'b0;
      lsr_q     <= '0;
      msr_q     <= '0;
      cnt_q     <= '0;
      word_stb  <= 1'b0;
      word_left <= 1'b0;
      lsb_word  <= '0;
      msb_word  <= '0;
      msb_cnt   <= '0;
    end else begin
      lr1_q     <= lr1_d;
      lr2_q     <= lr2_d;
      hist_q    <= hist_d;
      armed_q   <= armed_d;
      lsr_q     <= lsr_d;
      msr_q     <= msr_d;
      cnt_q     <= cnt_d;
      word_stb  <= stb_d;
      word_left <= left_d;
      lsb_word  <= lword_d;
      msb_word  <= mword_d;
      msb_cnt   <= mcnt_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W_C);                                                   // R5
  AST_STB_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> $past(bit_stb));                                    // R2
  AST_STB_WORD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> msb_cnt != '0);                                     // R10

endmodule

// File: rtl/aud_rx_out.sv
module aud_rx_out
  import aud_rx_pkg::*;
#(
  parameter int W  = 18,
  parameter int SW = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt,
  input  logic          word_stb,
  input  logic          word_left,
  input  logic [W-1:0]  lsb_word,
  input  logic [W-1:0]  msb_word,
  input  logic [CW-1:0] msb_cnt,
  output logic [W-1:0]  left_data,
  output logic          left_vld,
  output logic [W-1:0]  right_data,
  output logic          right_vld
);

  localparam logic [CW-1:0] W_C = CW'(W);

  logic [W-1:0]  sample;
  logic [CW-1:0] shamt;
  logic [W-1:0]  ldat_d, rdat_d;
  logic          lvld_d, rvld_d;

  always_comb begin
    shamt = W_C - msb_cnt;
    unique case (fmt)
      FMT_END16: sample = {{(W-SW){lsb_word[SW-1]}}, lsb_word[SW-1:0]};
      FMT_END18: sample = lsb_word;
      default:   sample = msb_word << shamt;
    endcase
    lvld_d = word_stb &&  word_left;
    rvld_d = word_stb && !word_left;
    ldat_d = lvld_d ? sample : left_data;
    rdat_d = rvld_d ? sample : right_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_data  <= '0;
      right_data <= '0;
      left_vld   <= 1'b0;
      right_vld  <= 1'b0;
    end else begin
      left_data  <= ldat_d;
      right_data <= rdat_d;
      left_vld   <= lvld_d;
      right_vld  <= rvld_d;
    end
  end

  AST_VLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_vld && right_vld));                                       // R9
  AST_LEFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    left_vld |=> !left_vld);                                         // R9
  AST_RIGHT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    right_vld |=> !right_vld);                                       // R9
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (left_vld && fmt == FMT_END16) |->
      (left_data[W-1:SW-1] == '0 || left_data[W-1:SW-1] == '1));     // R4

endmodule

// File: rtl/aud_rx.sv
module aud_rx
  import aud_rx_pkg::*;
#(
  parameter int W      = 18,
  parameter int SW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt,
  input  logic          bclk,
  input  logic          lrclk,
  input  logic          sdata,
  output logic [W-1:0]  left_data,
  output logic          left_vld,
  output logic [W-1:0]  right_data,
  output logic          right_vld
);

  localparam int CW = $clog2(W + 1);

  logic          bit_stb, bit_val, lr_val;
  logic          word_stb, word_left;
  logic [W-1:0]  lsb_word, msb_word;
  logic [CW-1:0] msb_cnt;

  aud_rx_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .bit_stb(bit_stb), .bit_val(bit_val), .lr_val(lr_val)
  );

  aud_rx_frame #(.W(W), .CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n), .fmt(fmt),
    .bit_stb(bit_stb), .bit_val(bit_val), .lr_val(lr_val),
    .word_stb(word_stb), .word_left(word_left),
    .lsb_word(lsb_word), .msb_word(msb_word), .msb_cnt(msb_cnt)
  );

  aud_rx_out #(.W(W), .SW(SW), .CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .fmt(fmt),
    .word_stb(word_stb), .word_left(word_left),
    .lsb_word(lsb_word), .msb_word(msb_word), .msb_cnt(msb_cnt),
    .left_data(left_data), .left_vld(left_vld),
    .right_data(right_data), .right_vld(right_vld)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!left_vld && !right_vld));                           // R10

endmodule

// File: tb/aud_rx_test.sv
module aud_rx_test;

  localparam int NP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'b11;
  logic        bclk = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic [17:0] left_data, right_data;
  logic        left_vld, right_vld;

  int checks = 0;
  int fails  = 0;
  int lcnt = 0;
  int rcnt = 0;
  string cur_req = "R1";
  logic [17:0] exp_l [0:NP-1];
  logic [17:0] exp_r [0:NP-1];
  logic        dly_bit = 1'b0;

  always #4 clk = ~clk;

  aud_rx uut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .bclk(bclk), .lrclk(lrclk),
    .sdata(sdata), .left_data(left_data), .left_vld(left_vld),
    .right_data(right_data), .right_vld(right_vld)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && left_vld) begin
      if (lcnt < NP) chk($sformatf("%s R9 left sample %0d", cur_req, lcnt), 32'(left_data), 32'(exp_l[lcnt]));
      else chk("R9 extra left strobe", 32'(lcnt), 32'(NP));
      lcnt++;
    end
    if (rst_n && right_vld) begin
      if (rcnt < NP) chk($sformatf("%s R9 right sample %0d", cur_req, rcnt), 32'(right_data), 32'(exp_r[rcnt]));
      else chk("R9 extra right strobe", 32'(rcnt), 32'(NP));
      rcnt++;
    end
  end

  function automatic logic [17:0] smp(input int cfg, input int idx);
    case (idx)
      0: return 18'h1FFFF;
      1: return 18'h20000;
      2: return 18'h00000;
      3: return 18'h3FFFF;
      4: return 18'h07FFF;
      5: return 18'h38000;
      default: return 18'((idx * 40503 + cfg * 977) ^ 18'h2A5A5);
    endcase
  endfunction

  function automatic logic slot_bit(input logic [1:0] f, input int h,
                                    input logic [17:0] s, input int i, input int salt);
    int w;
    logic junk;
    junk = ((i * 5 + salt) % 3) == 0;
    if (f == 2'b00 || f == 2'b01) begin
      w = (f == 2'b00) ? 16 : 18;
      if (i >= h - w) return s[w - 1 - (i - (h - w))];
      return junk;
    end
    w = (h < 18) ? h : 18;
    if (i < w) return s[17 - i];
    return junk;
  endfunction

  task automatic send_bit(input logic lr, input logic d);
    lrclk = lr;
    if (fmt == 2'b11) begin
      sdata   = dly_bit;
      dly_bit = d;
    end else begin
      sdata = d;
    end
    bclk = 1'b0;
    repeat (4) @(posedge clk);
    #1 bclk = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic run_cfg(input logic [1:0] f, input int h, input int cfg, input string req);
    logic lvl_left;
    logic [17:0] s;
    cur_req = req;
    for (int k = 0; k < NP; k++) begin
      for (int ch = 0; ch < 2; ch++) begin
        s = smp(cfg, k * 2 + ch);
        case (f)
          2'b00:   s = {{2{s[15]}}, s[15:0]};
          2'b11:   s = (h < 18) ? {s[17:2], 2'b00} : s;
          default: s = s;
        endcase
        if (ch == 0) exp_l[k] = s; else exp_r[k] = s;
      end
    end
    rst_n = 1'b0;
    fmt   = f;
    bclk  = 1'b0;
    dly_bit = 1'b0;
    lvl_left = (f == 2'b11) ? 1'b0 : 1'b1;
    lrclk = ~lvl_left;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset left_data", 32'(left_data), 32'd0);
    chk("R10 reset right_data", 32'(right_data), 32'd0);
    chk("R10 reset valids", {30'd0, left_vld, right_vld}, 32'd0);
    lcnt = 0;
    rcnt = 0;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    for (int i = 0; i < 5; i++) send_bit(~lvl_left, 1'(i & 1));
    for (int k = 0; k < NP; k++) begin
      for (int ch = 0; ch < 2; ch++) begin
        s = smp(cfg, k * 2 + ch);
        for (int i = 0; i < h; i++)
          send_bit(ch == 0 ? lvl_left : ~lvl_left, slot_bit(f, h, s, i, k + ch + cfg));
      end
    end
    for (int i = 0; i < h; i++) send_bit(lvl_left, 1'(i % 3 == 1));
    repeat (20) @(posedge clk);
    #1;
    chk($sformatf("%s R9 R10 left strobe count", req), 32'(lcnt), 32'(NP));
    chk($sformatf("%s R9 R10 right strobe count", req), 32'(rcnt), 32'(NP));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 R2 R3 R4 R8: end-aligned 16-bit, padding before data
    run_cfg(2'b00, 16, 1, "R1 R3 R4 R8");
    run_cfg(2'b00, 17, 2, "R1 R3 R4 R8");
    run_cfg(2'b00, 32, 3, "R1 R3 R4 R8");
    // R3 R8: end-aligned 18-bit
    run_cfg(2'b01, 18, 4, "R1 R2 R3 R8");
    run_cfg(2'b01, 24, 5, "R1 R2 R3 R8");
    run_cfg(2'b01, 32, 6, "R1 R2 R3 R8");
    // R5 R8: start-aligned, padding after data
    run_cfg(2'b10, 18, 7, "R1 R2 R5 R8");
    run_cfg(2'b10, 32, 8, "R1 R2 R5 R8");
    // R6 R7: delayed framing, left on low word-select
    run_cfg(2'b11, 16, 9, "R1 R6 R7");
    run_cfg(2'b11, 18, 10, "R1 R2 R6");
    run_cfg(2'b11, 32, 11, "R1 R2 R6");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule